// File: doc/BRIEF.md
# Write-Enable-Gated Configuration Port

This block sits behind a serial bus slave in a supervisor device and turns received byte writes into register updates. The slave reports the start of a transaction, presents one address and data byte with a strobe, and later reports either a valid stop or a fresh start. A volatile write-enable latch decides whether each byte is acknowledged and whether it is committed when the transaction closes. Two exact byte patterns aimed at the control register always get through, because they are the only way to open or close the latch. Every other write needs the latch to be open.

The control register also carries a two-bit power-up delay code. A timer holds the power-on reset output high after the block leaves reset. It releases that output once the elapsed cycle count reaches the delay that the code selects. The output never comes back until the next reset. The four delays are parameters given in clock cycles, so a fast clock or a simulation can scale them.

Top module: `wegate_cfg_regs`

## Requirements
- R1: After reset, `weLatch` is 0, `ackOut` is 0, `porOut` is 1, the general registers read 0x00, and the control register reads 0x10. That value is the power-up code 01 in bits 5:4 and the enable view in bit 1 at 0.
- R2: While the latch is clear, a byte gets no acknowledge and leaves all state unchanged. This holds for a byte to any address, the control register included, unless it is one of the two latch patterns.
- R3: A byte equal to 0x02 (bit 1 set, all others 0) written to the control address is acknowledged whatever the latch state. When its stop arrives, it sets the latch and leaves the other control bits unchanged.
- R4: A byte equal to 0x00 written to the control address is acknowledged whatever the latch state. When its stop arrives, it clears the latch and leaves the other control bits unchanged.
- R5: `ackOut` is a single-cycle pulse in the cycle right after the cycle in which `byteValid` was sampled, and it appears only for an accepted byte.
- R6: While the latch is set, any other byte is acknowledged and committed at stop. A byte to the control address stores every bit except bit 1, and bits 5:4 become the power-up code. A byte to address 0 to NUM_REGS-1 is stored in that register. The latch itself keeps its value.
- R7: A pending write is committed only on `txStop`. A `txStart` that arrives before the stop discards it, and no register or latch changes.
- R8: The latch value set by a stop takes effect in the very next cycle. A byte strobed right after the stop edge is judged against the new latch value.
- R9: `porOut` stays high for exactly DLY0, DLY1, DLY2 or DLY3 clock edges after reset release, for power-up codes 00, 01, 10 and 11 respectively. It then falls and stays low until the next reset.
- R10: The timer reads the power-up code as it stands at each edge. A code written on the same edge that the old code ends the hold still releases the reset. A code whose delay has already elapsed releases the reset on the edge after its commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| txStart | input | 1 | Start condition seen by the bus slave (one-cycle pulse) |
| txStop | input | 1 | Valid stop condition seen by the bus slave (one-cycle pulse) |
| byteValid | input | 1 | Address and data byte received (one-cycle pulse) |
| wrAddr | input | ADDR_W | Target address of the received byte |
| wrData | input | DATA_W | Received data byte |
| ackOut | output | 1 | Acknowledge decision for the last byte, one cycle after `byteValid` |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Register contents at `rdAddr`, including the live latch in bit 1 of the control register |
| weLatch | output | 1 | Current write-enable latch |
| porOut | output | 1 | Power-on reset output, active high |

## Verification
Two functions can land on one clock edge: a committed control-register write that changes the power-up code, and the reset timer's terminal-count decision. The bench opens the latch and leaves a code-11 write pending. It then places the stop pulse so that the commit edge is exactly the edge on which the default code's delay expires. It judges that the reset falls on that edge, as the old code requires, rather than waiting for the longer new delay. A second case commits a short code after that code's delay has already elapsed, and expects the release one edge after the commit.

// File: rtl/wegate_cfg_pkg.sv
`timescale 1ns/1ps
package wegate_cfg_pkg;

  // Strobes from control to datapath when a pending write is committed.
  typedef struct packed {
    logic ctrlWr;  // store data byte into the control register
    logic memWr;   // store data byte into a general register
  } commitStb_t;

  // Classification of a received byte.
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SET   = 2'd1,  // exact latch-open pattern to the control address
    KIND_CLEAR = 2'd2,  // exact latch-close pattern to the control address
    KIND_DATA  = 2'd3   // anything else
  } wrKind_e;

endpackage

// File: rtl/wegate_cfg_ctrl.sv
`timescale 1ns/1ps
module wegate_cfg_ctrl
  import wegate_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1,
  parameter int WE_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic              txStop,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              ackOut,
  output logic              weLatch,
  output commitStb_t        stb,
  output logic [ADDR_W-1:0] cmtAddr,
  output logic [DATA_W-1:0] cmtData
);

  localparam logic [DATA_W-1:0] SET_PAT = DATA_W'(1) << WE_BIT;

  wrKind_e           inKind;
  wrKind_e           pendKind;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic              hitCtrl;
  logic              accept;
  logic              doCommit;
  logic              latchQ;

  // Classify the incoming byte and decide whether it is accepted.
  always_comb begin
    hitCtrl = (wrAddr == CTRL_ADDR);
    if (hitCtrl && wrData == SET_PAT)   inKind = KIND_SET;
    else if (hitCtrl && wrData == '0)   inKind = KIND_CLEAR;
    else                                inKind = KIND_DATA;
    accept   = (inKind != KIND_DATA) || latchQ;
    doCommit = txStop && pendValid;
  end

  // Pending write capture and acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendKind  <= KIND_NONE;
      pendAddr  <= '0;
      pendData  <= '0;
      ackOut    <= 1'b0;
    end else begin
      ackOut <= byteValid && accept;
      if (txStart || doCommit) pendValid <= 1'b0;
      if (byteValid) begin
        pendValid <= accept;
        pendKind  <= inKind;
        pendAddr  <= wrAddr;
        pendData  <= wrData;
      end
    end
  end

  // Volatile write-enable latch, changed only by committed patterns.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (doCommit) begin
      if (pendKind == KIND_SET)        latchQ <= 1'b1;
      else if (pendKind == KIND_CLEAR) latchQ <= 1'b0;
    end
  end

  always_comb begin
    stb.ctrlWr = doCommit && (pendKind == KIND_DATA) && (pendAddr == CTRL_ADDR);
    stb.memWr  = doCommit && (pendKind == KIND_DATA) && (pendAddr != CTRL_ADDR);
    cmtAddr    = pendAddr;
    cmtData    = pendData;
    weLatch    = latchQ;
  end

endmodule

// File: rtl/wegate_cfg_dpath.sv
`timescale 1ns/1ps
module wegate_cfg_dpath
  import wegate_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1,
  parameter int WE_BIT = 1,
  parameter int PUP_LSB = 4,
  parameter logic [1:0] PUP_RESET = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  commitStb_t        stb,
  input  logic [ADDR_W-1:0] cmtAddr,
  input  logic [DATA_W-1:0] cmtData,
  input  logic              weLatch,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        pupSel
);

  localparam logic [DATA_W-1:0] WE_MASK   = DATA_W'(1) << WE_BIT;
  localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(PUP_RESET) << PUP_LSB;

  logic [DATA_W-1:0] ctrlStore;
  logic [DATA_W-1:0] ctrlView;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  // Control register: the enable bit position is never stored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlStore <= CTRL_INIT;
    else if (stb.ctrlWr) ctrlStore <= cmtData & ~WE_MASK;
  end

  // General registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (stb.memWr) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (cmtAddr == ADDR_W'(i)) regFile[i] <= cmtData;
    end
  end

  always_comb begin
    ctrlView         = ctrlStore;
    ctrlView[WE_BIT] = weLatch;
    pupSel           = ctrlStore[PUP_LSB +: 2];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == CTRL_ADDR) rdData = ctrlView;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdData = regFile[i];
  end

endmodule

// File: rtl/wegate_cfg_por.sv
`timescale 1ns/1ps
module wegate_cfg_por #(
  parameter int unsigned DLY0 = 50000,
  parameter int unsigned DLY1 = 200000,
  parameter int unsigned DLY2 = 400000,
  parameter int unsigned DLY3 = 800000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pupSel,
  output logic       porOut
);

  localparam int unsigned MAX01 = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int unsigned MAX23 = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int unsigned DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W = $clog2(DMAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             done;

  // Last count value of the hold for the current code.
  always_comb begin
    unique case (pupSel)
      2'b00:   limit = CNT_W'(DLY0 - 1);
      2'b01:   limit = CNT_W'(DLY1 - 1);
      2'b10:   limit = CNT_W'(DLY2 - 1);
      default: limit = CNT_W'(DLY3 - 1);
    endcase
  end

  // Count once per edge; stop for good once the hold has elapsed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt >= limit) done <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  assign porOut = !done;

endmodule

// File: rtl/wegate_cfg_regs.sv
`timescale 1ns/1ps
module wegate_cfg_regs
  import wegate_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1,
  parameter int WE_BIT = 1,
  parameter int PUP_LSB = 4,
  parameter logic [1:0] PUP_RESET = 2'b01,
  parameter int unsigned DLY0 = 50000,
  parameter int unsigned DLY1 = 200000,
  parameter int unsigned DLY2 = 400000,
  parameter int unsigned DLY3 = 800000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic              txStop,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              ackOut,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              weLatch,
  output logic              porOut
);

  commitStb_t        stb;
  logic [ADDR_W-1:0] cmtAddr;
  logic [DATA_W-1:0] cmtData;
  logic [1:0]        pupSel;

  wegate_cfg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .WE_BIT(WE_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txStop(txStop),
    .byteValid(byteValid), .wrAddr(wrAddr), .wrData(wrData),
    .ackOut(ackOut), .weLatch(weLatch), .stb(stb),
    .cmtAddr(cmtAddr), .cmtData(cmtData)
  );

  wegate_cfg_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .CTRL_ADDR(CTRL_ADDR), .WE_BIT(WE_BIT), .PUP_LSB(PUP_LSB),
    .PUP_RESET(PUP_RESET)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmtAddr(cmtAddr),
    .cmtData(cmtData), .weLatch(weLatch), .rdAddr(rdAddr),
    .rdData(rdData), .pupSel(pupSel)
  );

  wegate_cfg_por #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
  ) u_por (
    .clk(clk), .rstN(rstN), .pupSel(pupSel), .porOut(porOut)
  );

endmodule

// File: rtl/wegate_cfg_chk.sv
`timescale 1ns/1ps
module wegate_cfg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1,
  parameter int WE_BIT = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              txStop,
  input logic              byteValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              ackOut,
  input logic              weLatch,
  input logic              porOut
);

  localparam logic [DATA_W-1:0] SET_PAT = DATA_W'(1) << WE_BIT;

  // R1: on leaving reset the latch is closed and reset is held
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!weLatch && porOut && !ackOut));

  // R2: a non-pattern byte while closed is never acknowledged
  a_r2_no_ack_closed: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !weLatch &&
     !(wrAddr == CTRL_ADDR && (wrData == SET_PAT || wrData == '0)))
    |=> !ackOut);

  // R5: an acknowledge always follows a byte strobe
  a_r5_ack_follows_byte: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(byteValid));

  // R7: the latch moves only on a stop condition
  a_r7_latch_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    !txStop |=> $stable(weLatch));

  // R9: once released, reset never re-arms
  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    !porOut |=> !porOut);

endmodule

bind wegate_cfg_regs wegate_cfg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .WE_BIT(WE_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .txStop(txStop), .byteValid(byteValid),
  .wrAddr(wrAddr), .wrData(wrData), .ackOut(ackOut),
  .weLatch(weLatch), .porOut(porOut)
);

// File: tb/wegate_cfg_regs_bench.sv
`timescale 1ns/1ps
module wegate_cfg_regs_bench;

  localparam int D0 = 10;
  localparam int D1 = 40;
  localparam int D2 = 80;
  localparam int D3 = 160;
  localparam logic [7:0] CA = 8'hFF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txStart = 1'b0;
  logic       txStop = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic       ackOut;
  logic [7:0] rdData;
  logic       weLatch;
  logic       porOut;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int relEdge = 0;
  bit relSeen = 1'b0;
  bit finished = 1'b0;
  int stopEdge = 0;

  wegate_cfg_regs #(.DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3)) u_wegate_cfg_regs (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txStop(txStop),
    .byteValid(byteValid), .wrAddr(wrAddr), .wrData(wrData),
    .ackOut(ackOut), .rdAddr(rdAddr), .rdData(rdData),
    .weLatch(weLatch), .porOut(porOut)
  );

  always #5 clk = ~clk;

  // Edge count since reset release: after edge k, cyc == k.
  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Record the edge at which porOut first reads low.
  always @(negedge clk) begin
    if (!rstN) relSeen = 1'b0;
    else if (!relSeen && !porOut) begin
      relSeen = 1'b1;
      relEdge = cyc;
    end
  end

  // Vector: {req, addr, data, useStop, expAck, expWe, expRd}
  localparam logic [30:0] VEC [13] = '{
    {4'd2,  8'h00, 8'h5A, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 memory write while closed
    {4'd2,  CA,    8'h13, 1'b1, 1'b0, 1'b0, 8'h10}, // R2 control write while closed
    {4'd4,  CA,    8'h00, 1'b1, 1'b1, 1'b0, 8'h10}, // R4 clear pattern while closed
    {4'd7,  CA,    8'h02, 1'b0, 1'b1, 1'b0, 8'h10}, // R7 set pattern aborted
    {4'd3,  CA,    8'h02, 1'b1, 1'b1, 1'b1, 8'h12}, // R3 set pattern opens latch
    {4'd6,  8'h00, 8'h5A, 1'b1, 1'b1, 1'b1, 8'h5A}, // R6 memory write while open
    {4'd6,  8'h03, 8'hA5, 1'b1, 1'b1, 1'b1, 8'hA5}, // R6 top register
    {4'd7,  8'h01, 8'h77, 1'b0, 1'b1, 1'b1, 8'h00}, // R7 aborted data write
    {4'd6,  CA,    8'h31, 1'b1, 1'b1, 1'b1, 8'h33}, // R6 control data write
    {4'd3,  CA,    8'h02, 1'b1, 1'b1, 1'b1, 8'h33}, // R3 set while open keeps bits
    {4'd4,  CA,    8'h00, 1'b1, 1'b1, 1'b0, 8'h31}, // R4 clear keeps bits
    {4'd2,  8'h00, 8'h11, 1'b1, 1'b0, 1'b0, 8'h5A}, // R2 memory untouched
    {4'd2,  CA,    8'h03, 1'b1, 1'b0, 1'b0, 8'h31}  // R2 near-pattern rejected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // Start, byte, then stop (or an abort by a fresh start). Returns ack.
  task automatic doTx(input logic [7:0] a, input logic [7:0] d,
                      input bit useStop, output logic ack);
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0; byteValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); byteValid = 1'b0; ack = ackOut;
    if (useStop) txStop = 1'b1; else txStart = 1'b1;
    stopEdge = cyc + 1;
    @(negedge clk); txStop = 1'b0; txStart = 1'b0;
  endtask

  task automatic waitRel();
    while (!relSeen && cyc < 2000) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic       ack;
    logic [7:0] rd;

    // ---- R1 reset state ----
    doReset();
    chk("R1 weLatch", weLatch, 0);
    chk("R1 ackOut", ackOut, 0);
    chk("R1 porOut", porOut, 1);
    readAt(CA, rd);   chk("R1 control reg", rd, 8'h10);
    readAt(8'h00, rd); chk("R1 reg0", rd, 8'h00);

    // ---- R9 default code 01 hold ----
    waitRel();
    chk("R9 default hold edges", relEdge, D1);

    // ---- vector walk ----
    foreach (VEC[i]) begin
      logic [30:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[30:27], i);
      doTx(v[26:19], v[18:11], v[10], ack);
      chk({tag, " ack"}, ack, v[9]);
      chk({tag, " latch"}, weLatch, v[8]);
      readAt(v[26:19], rd);
      chk({tag, " readback"}, rd, v[7:0]);
    end
    chk("R9 no re-arm after traffic", porOut, 0);

    // ---- R8 / R5: latch set by a stop is used on the next cycle ----
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0; byteValid = 1'b1; wrAddr = CA; wrData = 8'h02;
    @(negedge clk); byteValid = 1'b0; txStop = 1'b1;
    @(negedge clk); txStop = 1'b0; byteValid = 1'b1; wrAddr = 8'h02; wrData = 8'h66;
    @(negedge clk); byteValid = 1'b0;
    chk("R8 ack right after stop", ackOut, 1);
    txStop = 1'b1;
    @(negedge clk); txStop = 1'b0;
    chk("R5 ack is one cycle", ackOut, 0);
    readAt(8'h02, rd); chk("R8 byte committed", rd, 8'h66);

    // ---- R10: code write on the terminal edge of the old code ----
    doReset();
    doTx(CA, 8'h02, 1'b1, ack);
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0; byteValid = 1'b1; wrAddr = CA; wrData = 8'h30;
    @(negedge clk); byteValid = 1'b0;
    while (cyc < D1 - 1) @(negedge clk);
    txStop = 1'b1;
    @(negedge clk); txStop = 1'b0;
    chk("R10 release on old terminal edge", porOut, 0);
    chk("R10 release edge", relEdge, D1);
    readAt(CA, rd); chk("R10 code stored", rd, 8'h32);

    // ---- R9: code 11 ----
    doReset();
    doTx(CA, 8'h02, 1'b1, ack);
    doTx(CA, 8'h30, 1'b1, ack);
    waitRel();
    chk("R9 code 11 hold edges", relEdge, D3);

    // ---- R9: code 10 ----
    doReset();
    doTx(CA, 8'h02, 1'b1, ack);
    doTx(CA, 8'h20, 1'b1, ack);
    waitRel();
    chk("R9 code 10 hold edges", relEdge, D2);

    // ---- R10: short code after its delay already elapsed ----
    doReset();
    doTx(CA, 8'h02, 1'b1, ack);
    while (cyc < 20) @(negedge clk);
    doTx(CA, 8'h01, 1'b1, ack);
    waitRel();
    chk("R10 release one edge after commit", relEdge, stopEdge + 1);

    repeat (5) @(negedge clk);
    chk("R9 stays released", porOut, 0);
    finish();
  end

endmodule